// File: doc/BRIEF.md
# T1 Transmit Frame Slip Buffer

This block is a two-frame elastic store that sits between a 2.048 Mb/s backplane stream and a 1.544 Mb/s T1 transmit stream. The backplane side writes 32 byte-wide channels per 125 µs frame into a 64-byte ring. The line side pulls 24 bytes per frame, one for each DS1 timeslot, with timeslot n taken from backplane channel n. Backplane channel 0 and channels 25 to 31 are stored but never sent.

Both sides run on one system clock. Each side has its own strobe and its own pointer, so a difference in strobe rates models drift between the two timing domains. When the read side finishes a frame, the block measures how far the write pointer leads the start of the next read frame. If that lead is too small, or the data has been waiting too long, the block performs a controlled slip of one whole frame. It repeats a frame when the margin is too small and skips one when the delay is too large. A slip flips a status bit, records its direction and raises a maskable one-cycle interrupt. A mode input turns the slip logic off completely.

Top module: `tx_slip_buffer`

## Requirements
- R1: Each cycle with `wr_stb` high stores `wr_data` in the next slot of a 64-slot ring. Slot index = frame*32 + channel. After reset the write slot is 0, and it wraps from 63 back to 0.
- R2: Each cycle with `rd_stb` high puts a byte on `rd_data` in the next cycle, with `rd_valid` high in that cycle only. The k-th read of a frame (k = 0..23, for timeslot k+1) returns slot read_frame*32 + (k+1).
- R3: Without a slip, the read frame alternates 0, 1, 0, … after every 24th read. After reset the read frame is 0 and the timeslot counter is 0.
- R4: On the 24th read of a frame the block computes D = (write slot − (other_frame*32 + 1)) mod 64, using the write slot as it was before that clock edge. If D ≤ 1 a repeat slip occurs: the read frame stays the same, and `slip_dir` becomes 0.
- R5: If D > 56 in the same test, a skip slip occurs: the read frame stays the same, and `slip_dir` becomes 1. For 2 ≤ D ≤ 56 there is no slip.
- R6: Every slip inverts `slip_tgl`. `slip_tgl` and `slip_dir` change at no other time.
- R7: `slip_irq` is high for exactly the one cycle after a slip edge, provided `irq_mask` was low at that edge. When `irq_mask` is high, the slip is still recorded in `slip_tgl` and `slip_dir`, but `slip_irq` stays low.
- R8: While `ima_mode` is high, no slip occurs. The read frame alternates after every 24th read, and `slip_tgl`, `slip_dir` and `slip_irq` do not change.
- R9: Synchronous reset clears both pointers, `slip_tgl`, `slip_dir`, `slip_irq` and `rd_valid`. Stored data is kept.
- R10: A write and the 24th read in the same cycle are both performed. The slip test uses the write slot from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ima_mode | input | 1 | High disables slip detection and correction |
| irq_mask | input | 1 | High suppresses the slip interrupt pulse |
| wr_stb | input | 1 | Write one backplane channel byte |
| wr_data | input | 8 | Backplane channel byte |
| rd_stb | input | 1 | Read one DS1 timeslot byte |
| rd_data | output | 8 | Timeslot byte, one cycle after `rd_stb` |
| rd_valid | output | 1 | Marks `rd_data` as valid |
| slip_tgl | output | 1 | Inverts on every slip |
| slip_dir | output | 1 | Direction of the last slip: 1 = skip, 0 = repeat |
| slip_irq | output | 1 | One-cycle slip interrupt |

## Verification
A backplane write and the frame-closing read can land in the same clock edge. In that case the distance test must use the write pointer from before the edge. The bench provokes this by leaving the write pointer at D = 1 and pulsing `wr_stb` together with the 24th `rd_stb`. Using the post-write pointer would give D = 2 and no slip. The bench judges the case in two ways. It expects a repeat slip, with `slip_tgl` flipped and `slip_dir` = 0. It also expects the next 24 bytes to come again from frame 0.

// File: rtl/tx_slip_pkg.sv
package tx_slip_pkg;
  // Direction code reported on slip_dir
  typedef enum logic {
    SLIP_REPEAT = 1'b0,
    SLIP_SKIP   = 1'b1
  } slip_dir_e;
endpackage

// File: rtl/tx_slip_ram.sv
// Simple dual-port store, read-first, registered read port (block RAM style).
module tx_slip_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/tx_slip_wr_ptr.sv
// Backplane write slot counter over a two-frame ring.
module tx_slip_wr_ptr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  output logic [ADDR_W-1:0] wpos
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst)         wpos <= '0;
    else if (wr_stb) wpos <= (wpos == LAST) ? '0 : wpos + ADDR_W'(1);
  end
endmodule

// File: rtl/tx_slip_rd_ctl.sv
// Line-side timeslot sequencer with frame-boundary slip decision.
module tx_slip_rd_ctl #(
  parameter int CH_PER_FRAME  = 32,
  parameter int TS_PER_FRAME  = 24,
  parameter int MIN_MARGIN_CH = 1,
  parameter int MAX_DELAY_CH  = 56
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                rd_stb,
  input  logic                                ima_mode,
  input  logic [$clog2(CH_PER_FRAME):0]       wpos,
  output logic [$clog2(CH_PER_FRAME):0]       raddr,
  output logic                                slip_ev,
  output tx_slip_pkg::slip_dir_e              slip_kind
);
  localparam int CH_W   = $clog2(CH_PER_FRAME);
  localparam int ADDR_W = CH_W + 1;
  localparam int TS_W   = $clog2(TS_PER_FRAME);
  localparam logic [TS_W-1:0]   TS_LAST = TS_W'(TS_PER_FRAME - 1);
  localparam logic [ADDR_W-1:0] MIN_L   = ADDR_W'(MIN_MARGIN_CH);
  localparam logic [ADDR_W-1:0] MAX_L   = ADDR_W'(MAX_DELAY_CH);

  logic            rd_frame;
  logic [TS_W-1:0] rd_ts;
  logic            frame_end;
  logic [ADDR_W-1:0] next_start;
  logic [ADDR_W-1:0] lead;
  logic            too_close;
  logic            too_long;

  // Timeslot n is carried in backplane channel n (channel 0 unused)
  assign raddr      = {rd_frame, CH_W'(rd_ts) + CH_W'(1)};
  assign frame_end  = rd_stb && (rd_ts == TS_LAST);
  assign next_start = {~rd_frame, CH_W'(1)};
  assign lead       = wpos - next_start;
  assign too_close  = (lead <= MIN_L);
  assign too_long   = (lead > MAX_L);
  assign slip_ev    = frame_end && !ima_mode && (too_close || too_long);
  assign slip_kind  = too_long ? tx_slip_pkg::SLIP_SKIP : tx_slip_pkg::SLIP_REPEAT;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_frame <= 1'b0;
      rd_ts    <= '0;
    end else if (rd_stb) begin
      rd_ts <= frame_end ? '0 : rd_ts + TS_W'(1);
      // In a two-frame ring both skip and repeat hold the frame index
      if (frame_end && !slip_ev) rd_frame <= ~rd_frame;
    end
  end
endmodule

// File: rtl/tx_slip_buffer.sv
module tx_slip_buffer #(
  parameter int DATA_W        = 8,
  parameter int CH_PER_FRAME  = 32,
  parameter int TS_PER_FRAME  = 24,
  parameter int MIN_MARGIN_CH = 1,
  parameter int MAX_DELAY_CH  = 56
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ima_mode,
  input  logic              irq_mask,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              slip_tgl,
  output logic              slip_dir,
  output logic              slip_irq
);
  localparam int ADDR_W = $clog2(CH_PER_FRAME) + 1;

  logic [ADDR_W-1:0]       wpos;
  logic [ADDR_W-1:0]       raddr;
  logic                    slip_ev;
  tx_slip_pkg::slip_dir_e  slip_kind;

  tx_slip_wr_ptr #(.ADDR_W(ADDR_W)) wr_ptr_i (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (wr_stb),
    .wpos   (wpos)
  );

  tx_slip_rd_ctl #(
    .CH_PER_FRAME  (CH_PER_FRAME),
    .TS_PER_FRAME  (TS_PER_FRAME),
    .MIN_MARGIN_CH (MIN_MARGIN_CH),
    .MAX_DELAY_CH  (MAX_DELAY_CH)
  ) rd_ctl_i (
    .clk       (clk),
    .rst       (rst),
    .rd_stb    (rd_stb),
    .ima_mode  (ima_mode),
    .wpos      (wpos),
    .raddr     (raddr),
    .slip_ev   (slip_ev),
    .slip_kind (slip_kind)
  );

  tx_slip_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
    .clk   (clk),
    .we    (wr_stb),
    .waddr (wpos),
    .wdata (wr_data),
    .re    (rd_stb),
    .raddr (raddr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      slip_tgl <= 1'b0;
      slip_dir <= 1'b0;
      slip_irq <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      slip_irq <= slip_ev && !irq_mask;
      if (slip_ev) begin
        slip_tgl <= ~slip_tgl;
        slip_dir <= slip_kind;
      end
    end
  end
endmodule

// File: rtl/tx_slip_buffer_chk.sv
module tx_slip_buffer_chk (
  input logic clk,
  input logic rst,
  input logic ima_mode,
  input logic irq_mask,
  input logic rd_stb,
  input logic rd_valid,
  input logic slip_tgl,
  input logic slip_dir,
  input logic slip_irq
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> !rd_valid);
  assert_tgl_needs_read_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(slip_tgl));
  assert_dir_with_tgl_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(slip_dir) |-> !$stable(slip_tgl));
  assert_irq_on_slip_R7: assert property (@(posedge clk) disable iff (rst)
    slip_irq |-> !$stable(slip_tgl));
  assert_irq_unmasked_R7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(slip_tgl) && !$past(irq_mask)) |-> slip_irq);
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
    $past(irq_mask) |-> !slip_irq);
  assert_ima_hold_R8: assert property (@(posedge clk) disable iff (rst)
    $past(ima_mode) |-> $stable(slip_tgl));
endmodule

bind tx_slip_buffer tx_slip_buffer_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .ima_mode (ima_mode),
  .irq_mask (irq_mask),
  .rd_stb   (rd_stb),
  .rd_valid (rd_valid),
  .slip_tgl (slip_tgl),
  .slip_dir (slip_dir),
  .slip_irq (slip_irq)
);

// File: tb/tx_slip_buffer_tb_top.sv
`timescale 1ns/1ps
module tx_slip_buffer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ima_mode = 1'b0;
  logic       irq_mask = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid, slip_tgl, slip_dir, slip_irq;

  always #10 clk = ~clk;

  tx_slip_buffer dut_i (
    .clk(clk), .rst(rst), .ima_mode(ima_mode), .irq_mask(irq_mask),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
    .rd_data(rd_data), .rd_valid(rd_valid), .slip_tgl(slip_tgl),
    .slip_dir(slip_dir), .slip_irq(slip_irq)
  );

  int errors = 0;
  int checks = 0;
  int wcnt   = 0;
  int seed   = 0;
  logic [7:0] model [64];

  // nwr: writes before reading; coll: write together with 24th read
  typedef struct packed {
    logic [7:0] nwr;
    logic       ima;
    logic       mask;
    logic       coll;
    logic       exp_slip;
    logic       exp_dir;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{8'd64, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // D=31 no slip R3
    '{8'd34, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // D=1 repeat R4
    '{8'd35, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // D=2 no slip R5
    '{8'd33, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // D=0 repeat R4
    '{8'd90, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // D=57 skip R5
    '{8'd89, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // D=56 no slip R5
    '{8'd34, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // ima mode R8
    '{8'd34, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // masked R7
    '{8'd34, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}   // coincident write R10
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_stb = 1'b0; rd_stb = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    wcnt = 0;
  endtask

  task automatic wr_one();
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_data = 8'(wcnt * 13 + seed * 29 + 7);
    model[wcnt % 64] = wr_data;
    wcnt++;
    @(posedge clk); #1;
    wr_stb = 1'b0;
  endtask

  // One read; optionally a write in the same cycle. Samples one edge later.
  task automatic rd_one(input logic wr_too, output logic [7:0] q, output logic irq);
    @(negedge clk);
    rd_stb = 1'b1;
    if (wr_too) begin
      wr_stb  = 1'b1;
      wr_data = 8'(wcnt * 13 + seed * 29 + 7);
      model[wcnt % 64] = wr_data;
      wcnt++;
    end
    @(posedge clk); #1;
    q = rd_data; irq = slip_irq;
    check("R2 rd_valid", int'(rd_valid), 1);
    rd_stb = 1'b0; wr_stb = 1'b0;
  endtask

  // Reads one frame and compares to model frame fr; returns irq seen on last read
  task automatic rd_frame_chk(input int fr, input logic coll_last, input string req,
                              output logic irq_last);
    logic [7:0] q;
    logic irq;
    irq_last = 1'b0;
    for (int k = 0; k < 24; k++) begin
      rd_one(coll_last && (k == 23), q, irq);
      check(req, int'(q), int'(model[fr * 32 + k + 1]));
      if (k == 23) irq_last = irq;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic irq;
    logic [7:0] q;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;

    // R9 reset state
    do_reset();
    @(posedge clk); #1;
    check("R9 slip_tgl", int'(slip_tgl), 0);
    check("R9 slip_dir", int'(slip_dir), 0);
    check("R9 slip_irq", int'(slip_irq), 0);
    check("R9 rd_valid", int'(rd_valid), 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      seed = v;
      ima_mode = VECS[v].ima;
      irq_mask = VECS[v].mask;
      do_reset();
      for (int n = 0; n < int'(VECS[v].nwr) - (VECS[v].coll ? 0 : 0); n++) wr_one();
      rd_frame_chk(0, VECS[v].coll, "R2 data frame A", irq);
      check("R6 slip_tgl", int'(slip_tgl), int'(VECS[v].exp_slip));
      check("R4/R5 slip_dir", int'(slip_dir), int'(VECS[v].exp_dir));
      check("R7 slip_irq", int'(irq), int'(VECS[v].exp_slip && !VECS[v].mask));
      // R3/R4/R5/R10: next frame is 0 after a slip, 1 otherwise
      rd_frame_chk(VECS[v].exp_slip ? 0 : 1, 1'b0, "R3 next frame data", irq);
      @(posedge clk); #1;
      check("R2 rd_valid idle", int'(rd_valid), 0);
      check("R7 irq one cycle", int'(slip_irq), 0);
    end
    ima_mode = 1'b0; irq_mask = 1'b0;

    // R6 double slip returns toggle to 0; R1 write ring wrap
    seed = 20;
    do_reset();
    for (int n = 0; n < 33; n++) wr_one();
    rd_frame_chk(0, 1'b0, "R2 data", irq);
    check("R6 first toggle", int'(slip_tgl), 1);
    rd_frame_chk(0, 1'b0, "R4 repeat data", irq);
    check("R6 second toggle", int'(slip_tgl), 0);
    check("R7 irq on second slip", int'(irq), 1);

    // R9 reset mid-run after a slip
    rd_frame_chk(0, 1'b0, "R4 repeat data", irq);
    check("R6 third toggle", int'(slip_tgl), 1);
    do_reset();
    @(posedge clk); #1;
    check("R9 tgl cleared", int'(slip_tgl), 0);
    check("R9 dir cleared", int'(slip_dir), 0);

    // R1 wrap: 64+40 writes, slot 0..39 overwritten by second lap
    seed = 30;
    for (int n = 0; n < 104; n++) wr_one();
    // D = (104 mod 64) - 33 = 7: no slip, frames 0 then 1
    rd_frame_chk(0, 1'b0, "R1 wrap data frame 0", irq);
    check("R5 no slip D=7", int'(slip_tgl), 0);
    rd_frame_chk(1, 1'b0, "R1 wrap data frame 1", irq);
    rd_one(1'b0, q, irq);
    check("R3 back to frame 0", int'(q), int'(model[1]));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule